// File: doc/BRIEF.md
# Utilization-Driven Link Power Controller

This block decides the power state of one vertical inter-die link attached to a router in a stacked network-on-chip. It measures how many cycles carry a flit during a fixed window of 2^WIN_LOG2 cycles. At the end of each window it compares that count against two programmable thresholds. A count above the upper threshold keeps the link fully active. A count inside the band between the thresholds puts the transmitter to sleep by gating both its clock and its supply. A count below the lower threshold switches the whole link off, transmitter and receiver alike.

The flit input is a valid/ready pair. `flit_vld_i` raises a request and `link_rdy_o` grants it. A flit counts as transferred only in a cycle where both are high. The router must hold the flit and keep `flit_vld_i` high while `link_rdy_o` is low. While the link sleeps, a valid flit wakes it at once, with no utilization check. The gate enables come back on the very next edge. `link_rdy_o` then stays low for a programmable settling time, so the flit is stalled rather than lost. A wake also restarts the measuring window. Thresholds, the wake time and the gate outputs are plain control pins.

Top module: `link_pwr_ctrl`

## Requirements
- R1: After reset the state code is 00 (active), all three gate enables are 1, `link_rdy_o` is 1, and the window starts empty, so the first decision happens on the 2^WIN_LOG2-th clock edge after reset release.
- R2: A decision is taken only on the last edge of each window of 2^WIN_LOG2 cycles. Utilization is the number of cycles in that window with `flit_vld_i` and `link_rdy_o` both high; stalled cycles are not counted.
- R3: If utilization at a decision is greater than `hi_thr_i`, an active link stays in state 00.
- R4: If `lo_thr_i` <= utilization <= `hi_thr_i`, an active link enters state 01 (transmitter dormant): `tx_clk_en_o`=0, `tx_pwr_en_o`=0, `rx_pwr_en_o`=1.
- R5: If utilization is less than `lo_thr_i`, the link enters state 10 (link off) with all three gate enables 0.
- R6: When `flit_vld_i` is high in state 01 or 10, the next edge sets state 00 with all gate enables 1, whatever the thresholds and the count.
- R7: After a waking edge, `link_rdy_o` stays low and goes high exactly `wake_cyc_i` edges later. It goes high on the waking edge itself when `wake_cyc_i` is 0. `link_rdy_o` is never high outside state 00.
- R8: The waking edge restarts the window, so the next decision falls 2^WIN_LOG2 edges after it.
- R9: The thresholds are read only at the decision edge. Their values earlier in the window have no effect.
- R10: Sleep only deepens without a flit. At a decision, a dormant link may go to state 10, but a link in state 10 never returns to state 01 or 00 without a flit.
- R11: The state code 11 is never output. The gate decoder treats 11 as active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flit_vld_i | input | 1 | Flit request toward the link (valid) |
| link_rdy_o | output | 1 | Link accepts a flit this cycle (ready) |
| lo_thr_i | input | WIN_LOG2+1 | Lower utilization threshold |
| hi_thr_i | input | WIN_LOG2+1 | Upper utilization threshold |
| wake_cyc_i | input | WAKE_W | Settling cycles after a wake |
| tx_clk_en_o | output | 1 | Transmitter clock enable |
| tx_pwr_en_o | output | 1 | Transmitter supply enable |
| rx_pwr_en_o | output | 1 | Receiver supply enable |
| state_o | output | 2 | 00 active, 01 transmitter dormant, 10 link off |

## Verification
The bench aims at the threshold edges: counts of exactly `hi_thr_i`, `hi_thr_i`+1, exactly `lo_thr_i` and `lo_thr_i`-1. An off-by-one compare there would pick the wrong sleep depth. It counts the wake settling cycles one by one. A timer that is short by one would grant a flit to a transmitter that is still settling, and one that is long by one would stall the router needlessly. After a wake it checks that the decision moves a full window later, and that the stalled request cycles were not counted. A design that skipped the restart or counted stalls would sleep early or choose the band. It also changes thresholds mid-window and lowers the lower threshold while the link is off. A design that latched thresholds early, or let a decision lighten the sleep, would show the wrong state code.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  // Encoding ordered by sleep depth: a larger code is a deeper sleep.
  typedef enum logic [1:0] {
    LPC_ACTIVE = 2'b00,
    LPC_TXDORM = 2'b01,
    LPC_OFF    = 2'b10
  } lpc_state_e;

  typedef struct packed {
    logic tx_clk;
    logic tx_pwr;
    logic rx_pwr;
  } lpc_gate_t;

  function automatic lpc_state_e lpc_deeper(lpc_state_e a, lpc_state_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpc_window.sv
module lpc_window #(
  parameter int WIN_LOG2 = 6,
  parameter int CNT_W    = WIN_LOG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             xfer_i,
  output logic             boundary_o,
  output logic [CNT_W-1:0] util_o
);
  localparam logic [WIN_LOG2-1:0] WinOne = WIN_LOG2'(1);

  logic [WIN_LOG2-1:0] win_q;
  logic [CNT_W-1:0]    use_q;

  assign boundary_o = &win_q;
  // Count seen at the decision edge includes the current cycle's transfer.
  assign util_o     = use_q + CNT_W'(xfer_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      use_q <= '0;
    end else if (restart_i) begin
      win_q <= '0;
      use_q <= '0;
    end else begin
      win_q <= win_q + WinOne;
      use_q <= boundary_o ? '0 : util_o;
    end
  end

endmodule

// File: rtl/lpc_classify.sv
module lpc_classify
  import lpc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] util_i,
  input  logic [CNT_W-1:0] lo_thr_i,
  input  logic [CNT_W-1:0] hi_thr_i,
  output lpc_state_e       pick_o
);
  // The lower compare wins if the thresholds are crossed.
  always_comb begin
    if (util_i < lo_thr_i)       pick_o = LPC_OFF;
    else if (util_i > hi_thr_i)  pick_o = LPC_ACTIVE;
    else                         pick_o = LPC_TXDORM;
  end

endmodule

// File: rtl/lpc_wake_timer.sv
module lpc_wake_timer #(
  parameter int WAKE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAKE_W-1:0] cycles_i,
  output logic              busy_o
);
  localparam logic [WAKE_W-1:0] CntOne = WAKE_W'(1);

  logic [WAKE_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= cycles_i;
    else if (busy_o)  cnt_q <= cnt_q - CntOne;
  end

endmodule

// File: rtl/lpc_gate_dec.sv
module lpc_gate_dec
  import lpc_pkg::*;
(
  input  logic [1:0] state_i,
  output lpc_gate_t  gate_o
);
  always_comb begin
    unique case (state_i)
      2'b01:   gate_o = '{tx_clk: 1'b0, tx_pwr: 1'b0, rx_pwr: 1'b1};
      2'b10:   gate_o = '{tx_clk: 1'b0, tx_pwr: 1'b0, rx_pwr: 1'b0};
      default: gate_o = '{tx_clk: 1'b1, tx_pwr: 1'b1, rx_pwr: 1'b1}; // 00 and spare 11
    endcase
  end

endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
  import lpc_pkg::*;
#(
  parameter int WIN_LOG2 = 6,
  parameter int WAKE_W   = 4,
  localparam int CNT_W   = WIN_LOG2 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flit_vld_i,
  output logic              link_rdy_o,
  input  logic [CNT_W-1:0]  lo_thr_i,
  input  logic [CNT_W-1:0]  hi_thr_i,
  input  logic [WAKE_W-1:0] wake_cyc_i,
  output logic              tx_clk_en_o,
  output logic              tx_pwr_en_o,
  output logic              rx_pwr_en_o,
  output logic [1:0]        state_o
);
  lpc_state_e       state_q, state_d, pick;
  lpc_gate_t        gate;
  logic             wake_go, settling, xfer, boundary;
  logic [CNT_W-1:0] util;

  // A waiting flit wakes a sleeping link without any utilization test.
  assign wake_go    = (state_q != LPC_ACTIVE) && flit_vld_i;
  assign link_rdy_o = (state_q == LPC_ACTIVE) && !settling;
  assign xfer       = flit_vld_i && link_rdy_o;

  lpc_window #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) win_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (wake_go),
    .xfer_i     (xfer),
    .boundary_o (boundary),
    .util_o     (util)
  );

  lpc_classify #(.CNT_W(CNT_W)) cls_i (
    .util_i   (util),
    .lo_thr_i (lo_thr_i),
    .hi_thr_i (hi_thr_i),
    .pick_o   (pick)
  );

  lpc_wake_timer #(.WAKE_W(WAKE_W)) wake_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wake_go),
    .cycles_i (wake_cyc_i),
    .busy_o   (settling)
  );

  always_comb begin
    state_d = state_q;
    if (wake_go)                    state_d = LPC_ACTIVE;
    else if (boundary && !settling) state_d = lpc_deeper(state_q, pick);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LPC_ACTIVE;
    else         state_q <= state_d;
  end

  lpc_gate_dec dec_i (
    .state_i (state_q),
    .gate_o  (gate)
  );

  assign tx_clk_en_o = gate.tx_clk;
  assign tx_pwr_en_o = gate.tx_pwr;
  assign rx_pwr_en_o = gate.rx_pwr;
  assign state_o     = state_q;

endmodule

// File: rtl/lpc_checker.sv
module lpc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       flit_vld_i,
  input logic       link_rdy_o,
  input logic       tx_clk_en_o,
  input logic       tx_pwr_en_o,
  input logic       rx_pwr_en_o,
  input logic [1:0] state_o
);
  p_active_gates_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00) |-> (tx_clk_en_o && tx_pwr_en_o && rx_pwr_en_o));

  p_dormant_gates_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01) |-> (!tx_clk_en_o && !tx_pwr_en_o && rx_pwr_en_o));

  p_off_gates_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10) |-> (!tx_clk_en_o && !tx_pwr_en_o && !rx_pwr_en_o));

  p_wake_now_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'b00 && flit_vld_i) |=> (state_o == 2'b00 && tx_clk_en_o && rx_pwr_en_o));

  p_rdy_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_rdy_o |-> (state_o == 2'b00));

  p_no_lighten_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10 && !flit_vld_i) |=> (state_o == 2'b10));

  p_code_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);

endmodule

bind link_pwr_ctrl lpc_checker chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flit_vld_i  (flit_vld_i),
  .link_rdy_o  (link_rdy_o),
  .tx_clk_en_o (tx_clk_en_o),
  .tx_pwr_en_o (tx_pwr_en_o),
  .rx_pwr_en_o (rx_pwr_en_o),
  .state_o     (state_o)
);

// File: tb/link_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_pwr_ctrl_tb_top;
  localparam int WIN_LOG2 = 6;
  localparam int WAKE_W   = 4;
  localparam int CNT_W    = WIN_LOG2 + 1;
  localparam int WIN      = 1 << WIN_LOG2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              flit_vld_i = 1'b0;
  logic [CNT_W-1:0]  lo_thr_i = '0;
  logic [CNT_W-1:0]  hi_thr_i = '0;
  logic [WAKE_W-1:0] wake_cyc_i = '0;
  logic              link_rdy_o, tx_clk_en_o, tx_pwr_en_o, rx_pwr_en_o;
  logic [1:0]        state_o;

  int checks = 0;
  int failures = 0;
  bit saw_code3 = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_pwr_ctrl #(.WIN_LOG2(WIN_LOG2), .WAKE_W(WAKE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .flit_vld_i(flit_vld_i), .link_rdy_o(link_rdy_o),
    .lo_thr_i(lo_thr_i), .hi_thr_i(hi_thr_i), .wake_cyc_i(wake_cyc_i),
    .tx_clk_en_o(tx_clk_en_o), .tx_pwr_en_o(tx_pwr_en_o), .rx_pwr_en_o(rx_pwr_en_o),
    .state_o(state_o)
  );

  always @(negedge clk) if (rst_ni && state_o == 2'b11) saw_code3 = 1'b1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int gates();
    return {tx_clk_en_o, tx_pwr_en_o, rx_pwr_en_o};
  endfunction

  task automatic do_reset(int lo, int hi, int w);
    rst_ni = 1'b0; flit_vld_i = 1'b0;
    lo_thr_i = CNT_W'(lo); hi_thr_i = CNT_W'(hi); wake_cyc_i = WAKE_W'(w);
    step(3);
    rst_ni = 1'b1;
  endtask

  // One full window from reset with n transferred flits at the start.
  task automatic run_window(int n);
    for (int i = 1; i <= WIN; i++) begin
      flit_vld_i = (i <= n);
      step(1);
    end
    flit_vld_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(4, 20, 0);
    chk("R1 state", state_o, 0);
    chk("R1 gates", gates(), 7);
    chk("R1 ready", link_rdy_o, 1);
  endtask

  task automatic t_window_off();
    do_reset(4, 20, 0);
    step(WIN - 1);
    chk("R2 no decision before window end", state_o, 0);
    step(1);
    chk("R5 idle window -> off", state_o, 2);
    chk("R5 off gates", gates(), 0);
  endtask

  task automatic t_band(int n, int exp_state, string req);
    do_reset(4, 20, 0);
    run_window(n);
    chk(req, state_o, exp_state);
    if (exp_state == 1) chk("R4 dormant gates tx off rx on", gates(), 1);
  endtask

  task automatic t_thresh_sample();
    do_reset(30, 40, 0);
    for (int i = 1; i <= WIN; i++) begin
      flit_vld_i = (i <= 10);
      if (i == 40) begin lo_thr_i = CNT_W'(4); hi_thr_i = CNT_W'(20); end
      step(1);
    end
    flit_vld_i = 1'b0;
    chk("R9 thresholds read at decision edge", state_o, 1);
    lo_thr_i = CNT_W'(30); hi_thr_i = CNT_W'(40);
    step(WIN - 1);
    chk("R9 mid-window change no effect", state_o, 1);
    step(1);
    chk("R10 dormant deepens to off", state_o, 2);
  endtask

  task automatic t_wake_dorm();
    do_reset(4, 20, 3);
    run_window(10);
    chk("R4 band -> dormant", state_o, 1);
    step(5);
    flit_vld_i = 1'b1;
    step(1);
    chk("R6 wake from dormant state", state_o, 0);
    chk("R6 wake gates", gates(), 7);
    chk("R7 ready low at wake", link_rdy_o, 0);
    step(2);
    chk("R7 ready low during settle", link_rdy_o, 0);
    step(1);
    chk("R7 ready after wake_cyc edges", link_rdy_o, 1);
    step(1);
    flit_vld_i = 1'b0;
    step(WIN - 5);
    chk("R8 no decision before restarted window ends", state_o, 0);
    step(1);
    chk("R8 R2 one counted flit -> off", state_o, 2);
  endtask

  task automatic t_wake_off();
    do_reset(4, 20, 0);
    run_window(0);
    chk("R5 off", state_o, 2);
    lo_thr_i = CNT_W'(0);
    step(WIN);
    chk("R10 off stays off with band pick", state_o, 2);
    flit_vld_i = 1'b1;
    step(1);
    chk("R6 wake from off", state_o, 0);
    chk("R6 wake from off gates", gates(), 7);
    chk("R7 ready at once with zero settle", link_rdy_o, 1);
    flit_vld_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_window_off();
    t_band(21, 0, "R3 above hi stays active");
    t_band(20, 1, "R4 equal hi -> dormant");
    t_band(4,  1, "R4 equal lo -> dormant");
    t_band(3,  2, "R5 below lo -> off");
    t_thresh_sample();
    t_wake_dorm();
    t_wake_off();
    chk("R11 code 11 never seen", int'(saw_code3), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule